// File: doc/BRIEF.md
# Zero-High-Bits Execution Unit

This integer execution unit keeps the low part of a source operand and clears every bit from a chosen position upward. The position is taken from the low byte of a second operand. An index that reaches or passes the active operand width clears nothing, and the carry flag reports this case. The unit also produces the zero, sign and overflow flag updates, each with its own write enable.

The unit checks that the processor mode and the encoding bits allow the operation. Real mode, virtual-8086 mode or a set vector-length bit raises an undefined-opcode fault, and in that case no flag or result write is enabled. Every output is registered. It appears one clock after the valid strobe, together with an output valid.

Top module: `zhb_exec_unit`

## Requirements
- R1: The bit position N is `idx_op[7:0]`. Bits 8 and above of `idx_op` have no effect on any output.
- R2: When N is below the operand size, `res_data` equals `src_op` with bits N through size-1 cleared. Bits below N are copied.
- R3: When N is at or above the operand size, `res_data` equals `src_op` truncated to the operand size.
- R4: `cf_val` is 1 when N is at or above the operand size, and 0 otherwise.
- R5: `zf_val` is 1 exactly when the result is zero at the operand size. `sf_val` equals result bit size-1. `of_val` is written as 0.
- R6: The operand size is 64 only when `cpu_mode` is 2'b11 (64-bit) and `enc_w` is 1. Otherwise it is 32, `enc_w` is ignored, and `res_data[63:32]` is zero.
- R7: A set `enc_l` raises `ud_fault`. In that case every flag write enable is low and `res_data` is zero.
- R8: A `cpu_mode` of 2'b00 (real) or 2'b01 (virtual-8086) raises `ud_fault`. Mode 2'b10 is protected mode and 2'b11 is 64-bit mode.
- R9: `af_we` and `pf_we` are never asserted, so those flags keep their prior values.
- R10: Outputs update one clock after `in_valid`, and `out_valid` follows it. A cycle without `in_valid` gives `out_valid`=0, `ud_fault`=0 and all write enables low, and `res_data` holds its value.
- R11: While `rst_n` is low, `out_valid`, `ud_fault`, `res_data`, all flag values and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands valid this cycle |
| src_op | input | 64 | Source operand |
| idx_op | input | 64 | Index operand (low byte used) |
| enc_w | input | 1 | Encoded width bit |
| enc_l | input | 1 | Encoded vector-length bit |
| cpu_mode | input | 2 | 00 real, 01 virtual-8086, 10 protected, 11 64-bit |
| out_valid | output | 1 | Registered result valid |
| res_data | output | 64 | Registered result |
| ud_fault | output | 1 | Undefined-opcode fault |
| cf_val | output | 1 | Carry flag value |
| zf_val | output | 1 | Zero flag value |
| sf_val | output | 1 | Sign flag value |
| of_val | output | 1 | Overflow flag value |
| cf_we | output | 1 | Carry flag write enable |
| zf_we | output | 1 | Zero flag write enable |
| sf_we | output | 1 | Sign flag write enable |
| of_we | output | 1 | Overflow flag write enable |
| af_we | output | 1 | Auxiliary-carry write enable (always 0) |
| pf_we | output | 1 | Parity write enable (always 0) |

## Verification
Uniform random index operands seldom give a low byte that lands exactly on the width boundaries 31, 32, 63 or 64. So the stimulus places 0, 31, 32, 63, 64 and 255 directly in the low byte and fills the upper 56 bits with random values. Random indices are also drawn mostly from 0 to 70 so they sit near the boundaries. Each boundary index is repeated with the width bit both set and clear, and in each processor mode. This shows whether the carry threshold and the cleared span move with the operand size.

// File: rtl/zhb_pkg.sv
package zhb_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_V86  = 2'b01,
    MODE_PROT = 2'b10,
    MODE_LONG = 2'b11
  } cpu_mode_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } zhb_flags_t;

endpackage

// File: rtl/zhb_mode_check.sv
module zhb_mode_check
  import zhb_pkg::*;
(
  input  logic [1:0] cpu_mode,
  input  logic       enc_w,
  input  logic       enc_l,
  output logic       fault,
  output logic       wide
);

  cpu_mode_e mode;
  logic      mode_bad;

  always_comb begin
    mode     = cpu_mode_e'(cpu_mode);
    mode_bad = (mode == MODE_REAL) || (mode == MODE_V86);
    fault    = mode_bad || enc_l;
    wide     = (mode == MODE_LONG) && enc_w;
  end

endmodule

// File: rtl/zhb_mask_gen.sv
module zhb_mask_gen #(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  output logic [XLEN-1:0]  keep,
  output logic             over
);

  localparam int CMP_W = 32;

  logic [CMP_W-1:0] idx_ext;
  logic             over_wide;
  logic             over_half;

  assign idx_ext = {{(CMP_W-IDX_W){1'b0}}, idx};

  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_keep
      if (g < HALF) begin : g_low
        assign keep[g] = (idx_ext > CMP_W'(g));
      end else begin : g_high
        assign keep[g] = wide && (idx_ext > CMP_W'(g));
      end
    end
  endgenerate

  always_comb begin
    over_wide = (idx_ext >= CMP_W'(XLEN));
    over_half = (idx_ext >= CMP_W'(HALF));
    over      = wide ? over_wide : over_half;
  end

endmodule

// File: rtl/zhb_flag_gen.sv
module zhb_flag_gen
  import zhb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] res,
  input  logic            wide,
  input  logic            over,
  output zhb_flags_t      flags
);

  logic zero_lo;
  logic zero_hi;

  always_comb begin
    zero_lo   = (res[HALF-1:0] == '0);
    zero_hi   = (res[XLEN-1:HALF] == '0);
    flags.cf  = over;
    flags.zf  = wide ? (zero_lo && zero_hi) : zero_lo;
    flags.sf  = wide ? res[XLEN-1] : res[HALF-1];
    flags.of  = 1'b0;
  end

endmodule

// File: rtl/zhb_exec_unit.sv
module zhb_exec_unit
  import zhb_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HALF  = XLEN / 2,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_op,
  input  logic [XLEN-1:0] idx_op,
  input  logic            enc_w,
  input  logic            enc_l,
  input  logic [1:0]      cpu_mode,
  output logic            out_valid,
  output logic [XLEN-1:0] res_data,
  output logic            ud_fault,
  output logic            cf_val,
  output logic            zf_val,
  output logic            sf_val,
  output logic            of_val,
  output logic            cf_we,
  output logic            zf_we,
  output logic            sf_we,
  output logic            of_we,
  output logic            af_we,
  output logic            pf_we
);

  logic             fault_c;
  logic             wide_c;
  logic [XLEN-1:0]  keep_c;
  logic             over_c;
  logic [XLEN-1:0]  res_c;
  zhb_flags_t       flags_c;
  logic             unused_idx_hi;

  assign unused_idx_hi = ^idx_op[XLEN-1:IDX_W];

  zhb_mode_check u_mode (
    .cpu_mode (cpu_mode),
    .enc_w    (enc_w),
    .enc_l    (enc_l),
    .fault    (fault_c),
    .wide     (wide_c)
  );

  zhb_mask_gen #(
    .XLEN  (XLEN),
    .HALF  (HALF),
    .IDX_W (IDX_W)
  ) u_mask (
    .idx  (idx_op[IDX_W-1:0]),
    .wide (wide_c),
    .keep (keep_c),
    .over (over_c)
  );

  always_comb begin
    res_c = src_op & keep_c;
    if (over_c) begin
      res_c = wide_c ? src_op : {{(XLEN-HALF){1'b0}}, src_op[HALF-1:0]};
    end
  end

  zhb_flag_gen #(
    .XLEN (XLEN),
    .HALF (HALF)
  ) u_flags (
    .res   (res_c),
    .wide  (wide_c),
    .over  (over_c),
    .flags (flags_c)
  );

  // next-state
  logic            vld_d, vld_q;
  logic            flt_d, flt_q;
  logic            we_d,  we_q;
  logic            res_en;
  logic [XLEN-1:0] res_d, res_q;
  zhb_flags_t      flg_d, flg_q;

  always_comb begin
    vld_d  = in_valid;
    flt_d  = in_valid && fault_c;
    we_d   = in_valid && !fault_c;
    res_en = in_valid;
    res_d  = fault_c ? '0 : res_c;
    flg_d  = (in_valid && !fault_c) ? flags_c : flg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      flt_q <= 1'b0;
      we_q  <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
      we_q  <= we_d;
      flg_q <= flg_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign ud_fault  = flt_q;
  assign res_data  = res_q;
  assign cf_val    = flg_q.cf;
  assign zf_val    = flg_q.zf;
  assign sf_val    = flg_q.sf;
  assign of_val    = flg_q.of;
  assign cf_we     = we_q;
  assign zf_we     = we_q;
  assign sf_we     = we_q;
  assign of_we     = we_q;
  assign af_we     = 1'b0;
  assign pf_we     = 1'b0;

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !ud_fault && !cf_we && !zf_we && !sf_we && !of_we));

  // R7
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!cf_we && !zf_we && !sf_we && !of_we && res_data == '0));

  // R8
  bad_mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cpu_mode[1]) |=> ud_fault);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ud_fault) |-> (zf_val == (res_data == '0)));

  // R5
  of_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    of_we |-> !of_val);

  // R2
  subset_of_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fault_c) |=> ((res_data & ~$past(src_op)) == '0));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(cpu_mode == 2'b11 && enc_w)) |=> (res_data[XLEN-1:HALF] == '0));

endmodule

// File: tb/tb_zhb_exec_unit.sv
module tb_zhb_exec_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_op, idx_op;
  logic        enc_w, enc_l;
  logic [1:0]  cpu_mode;
  logic        out_valid, ud_fault;
  logic [63:0] res_data;
  logic        cf_val, zf_val, sf_val, of_val;
  logic        cf_we, zf_we, sf_we, of_we, af_we, pf_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zhb_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_op(src_op),
    .idx_op(idx_op), .enc_w(enc_w), .enc_l(enc_l), .cpu_mode(cpu_mode),
    .out_valid(out_valid), .res_data(res_data), .ud_fault(ud_fault),
    .cf_val(cf_val), .zf_val(zf_val), .sf_val(sf_val), .of_val(of_val),
    .cf_we(cf_we), .zf_we(zf_we), .sf_we(sf_we), .of_we(of_we),
    .af_we(af_we), .pf_we(pf_we)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int op_size(logic [1:0] m, logic w);
    return (m == 2'b11 && w) ? 64 : 32;
  endfunction

  function automatic logic [63:0] ref_res(logic [63:0] s, logic [63:0] ix, int sz);
    logic [63:0] r;
    int n;
    n = int'(ix[7:0]);
    r = '0;
    for (int b = 0; b < sz; b++) if (b < n) r[b] = s[b];
    return r;
  endfunction

  task automatic run(logic [63:0] s, logic [63:0] ix, logic w, logic l, logic [1:0] m);
    int sz;
    logic [63:0] er;
    logic flt;
    @(negedge clk);
    in_valid = 1'b1; src_op = s; idx_op = ix; enc_w = w; enc_l = l; cpu_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
    sz  = op_size(m, w);
    flt = l || (m[1] == 1'b0);
    check("R10", "out_valid", 64'(out_valid), 64'd1);
    if (flt) begin
      check(l ? "R7" : "R8", "ud_fault", 64'(ud_fault), 64'd1);
      check("R7", "write enables", 64'({cf_we, zf_we, sf_we, of_we}), 64'd0);
      check("R7", "res_data", res_data, 64'd0);
    end else begin
      er = ref_res(s, ix, sz);
      check("R8", "ud_fault", 64'(ud_fault), 64'd0);
      check(int'(ix[7:0]) >= sz ? "R3" : "R2", "res_data", res_data, er);
      check("R4", "cf_val", 64'(cf_val), 64'(int'(ix[7:0]) >= sz));
      check("R5", "zf_val", 64'(zf_val), 64'(er == 64'd0));
      check("R5", "sf_val", 64'(sf_val), 64'(er[sz-1]));
      check("R5", "of_val", 64'(of_val), 64'd0);
      check("R10", "write enables", 64'({cf_we, zf_we, sf_we, of_we}), 64'hF);
    end
    check("R9", "af/pf we", 64'({af_we, pf_we}), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] last;
    int bnd [6] = '{0, 31, 32, 63, 64, 255};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; src_op = '1; idx_op = '0;
    enc_w = 1'b0; enc_l = 1'b0; cpu_mode = 2'b11;
    repeat (3) @(negedge clk);
    check("R11", "reset outputs",
          64'({out_valid, ud_fault, cf_val, zf_val, sf_val, of_val,
               cf_we, zf_we, sf_we, of_we, af_we, pf_we}), 64'd0);
    check("R11", "reset res_data", res_data, 64'd0);
    rst_n = 1'b1;

    // boundary indices with random upper index bits, both widths, all modes
    foreach (bnd[k]) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 2; w++) begin
          run({$urandom, $urandom}, {$urandom, $urandom, 8'(bnd[k])} , 1'(w), 1'b0, 2'(m));
        end
      end
    end

    // R1: same low byte, different high bits must match
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD_0000_0000_0028, 1'b1, 1'b0, 2'b11);
    last = res_data;
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0028, 1'b1, 1'b0, 2'b11);
    check("R1", "upper index bits ignored", res_data, last);

    // R7 with valid mode; R6 width bit ignored in protected mode
    run(64'h1234_5678_9ABC_DEF0, 64'd8, 1'b1, 1'b1, 2'b11);
    run(64'hFFFF_FFFF_8000_0000, 64'd64, 1'b1, 1'b0, 2'b10);
    check("R6", "upper half zero", {32'd0, res_data[63:32]}, 64'd0);
    run(64'h8000_0000_0000_0000, 64'd200, 1'b1, 1'b0, 2'b11);
    run(64'h0000_0000_0000_0000, 64'd3, 1'b0, 1'b0, 2'b11);

    // R10: idle cycle holds result, no writes
    last = res_data;
    @(negedge clk);
    check("R10", "idle out_valid", 64'(out_valid), 64'd0);
    check("R10", "idle fault/we", 64'({ud_fault, cf_we, zf_we, sf_we, of_we}), 64'd0);
    check("R10", "idle res hold", res_data, last);

    // random, indices weighted to boundary region
    for (int t = 0; t < 400; t++) begin
      logic [63:0] ix;
      ix = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) ix[7:0] = 8'($urandom_range(0, 70));
      run({$urandom, $urandom}, ix, 1'($urandom), ($urandom_range(0, 9) == 0),
          ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule